// File: doc/BRIEF.md
# Line Buffer Command and Mode Controller

This block is the host-facing front end of a line buffer that holds up to 320 words of 16 bits. It watches a 16-bit processor write bus together with a DMA acknowledge line. Each write strobe becomes one of three things: a command, a data word, or nothing. Commands are identified by their top nibble. They load the configuration registers and move the block between three modes: idle (static), filling (write) and transmitting (send). A fourth internal state marks a finished transmission.

Data words go into an external line memory through a simple write port, at an address that starts at zero each time write mode is entered. A fill command can stand in for data. It writes a whole line of the fixed polarity word at one word per cycle. Transmission itself is done by an external serial engine. This block gives that engine a one-cycle start pulse, the stored word count and the configuration fields. It waits for a done pulse, then raises the ready indication and requests an interrupt.

All bus inputs come from outside the internal clock domain and are synchronised first. A write takes effect when the synchronised strobe rises.

Top module: `linebuf_ctrl`

## Requirements
- R1: A strobe rise with `bus_cs_n`=0 and `bus_cmd_sel`=1 is a command. A strobe rise with `bus_cs_n`=0 and `bus_cmd_sel`=0, or with `bus_dack_n`=0, is a data word. A strobe rise with both `bus_cs_n` and `bus_dack_n` high has no effect.
- R2: In write mode, each data word is written to the line memory once, at an address that starts at 0 when write mode is entered and rises by one per word. Data words in any other mode are not written.
- R3: Four commands are accepted only in static mode. Initialise (opcode 1000) loads the clock select (bit 11), the divider (bits 10:8), DMA request enable (bit 5), leading fill enable (bit 4) and fill polarity (bit 3). Opcode 0111 loads the request count N (bits 8:0). Opcode 0110 loads the leading length (bits 11:0). Opcode 0100 loads LIFO (bit 1) and LSB-first (bit 0).
- R4: Data or fill words beyond the 320th are dropped, and `line_words` saturates at 320.
- R5: The mode command (opcode 0000) is ignored unless bits 2:1 are 0. With bit 0 = 0 it enters write mode, from static mode or after a finished send. With bit 0 = 1 it starts a send, but only from write mode with no fill in progress.
- R6: On entering write mode with request enable set and mask bit 3 = 0, `dreq_n` goes low. It returns high once N+1 words have been stored. It is never low outside write mode.
- R7: A send start pulses `send_start` for one cycle and drives `busy_n` low. While `busy_n` is low, every command except stop is ignored and data words are not stored.
- R8: A `send_done` pulse during a send raises `busy_n` and lowers `intr_n` on the same edge.
- R9: Any host access (command or data, at any mode) drives `intr_n` high.
- R10: The fill command (opcode 0011, W in bits 8:0) is accepted only in write mode. It writes W+1 words, each equal to the fill polarity repeated across 16 bits, one per cycle from the current address.
- R11: The repeat command (opcode 0010) is accepted only after a finished send. It starts a new send with the same `line_words`.
- R12: Stop (opcode 1111) is accepted in every mode. It returns to static mode and clears the word count, the request, busy and interrupt. The four configuration registers keep their values.
- R13: After reset, all configuration fields are 0, `dreq_n`, `busy_n` and `intr_n` are high, and `mem_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_n | input | 1 | Write strobe, acts on its rising edge |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_cmd_sel | input | 1 | 1 = command, 0 = data |
| bus_dack_n | input | 1 | DMA acknowledge, active low |
| bus_data | input | 16 | Write bus data |
| send_done | input | 1 | Serial engine finished the line |
| mem_we | output | 1 | Line memory write enable |
| mem_addr | output | 9 | Line memory word address |
| mem_wdata | output | 16 | Line memory write data |
| send_start | output | 1 | One-cycle send start pulse |
| line_words | output | 9 | Words stored in the current line |
| cfg_clk_sel | output | 1 | Clock source select |
| cfg_div | output | 3 | Clock divider code |
| cfg_fill_pol | output | 1 | Fixed fill polarity |
| cfg_lead_en | output | 1 | Leading fill enable |
| cfg_lead_len | output | 12 | Leading fill length |
| cfg_lsb_first | output | 1 | Bit order select |
| cfg_lifo | output | 1 | Word order select |
| dreq_n | output | 1 | DMA request, active low |
| busy_n | output | 1 | Busy / output ready, low while sending |
| intr_n | output | 1 | Interrupt request, active low |

## Verification
A strobe rise driven between clock edges is seen on the second clock edge after it. Every register and output it affects changes on the third edge. The bench drives the strobe on falling edges and holds the bus fields steady for six cycles after the rise before it samples anything. A fill of W+1 words needs one more cycle per word, so the bench waits W+10 cycles before counting the memory writes it captured. A `send_done` pulse acts on the next rising edge, and the bench samples `busy_n` and `intr_n` on the falling edge that follows.

// File: rtl/linebuf_pkg.sv
package linebuf_pkg;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_WRITE  = 2'd1,
        MODE_SEND   = 2'd2,
        MODE_SENT   = 2'd3
    } mode_e;

    localparam logic [3:0] OPC_INIT   = 4'b1000;
    localparam logic [3:0] OPC_REQCNT = 4'b0111;
    localparam logic [3:0] OPC_LEAD   = 4'b0110;
    localparam logic [3:0] OPC_FMT    = 4'b0100;
    localparam logic [3:0] OPC_MODE   = 4'b0000;
    localparam logic [3:0] OPC_FILL   = 4'b0011;
    localparam logic [3:0] OPC_REPEAT = 4'b0010;
    localparam logic [3:0] OPC_STOP   = 4'b1111;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_INIT,
        CMD_REQCNT,
        CMD_LEAD,
        CMD_FMT,
        CMD_MODE,
        CMD_FILL,
        CMD_REPEAT,
        CMD_STOP,
        CMD_DATA
    } cmd_e;

    typedef struct packed {
        logic       clk_sel;
        logic [2:0] div;
        logic       req_en;
        logic       lead_en;
        logic       fill_pol;
    } init_cfg_t;

endpackage

// File: rtl/linebuf_bus_sync.sv
module linebuf_bus_sync #(
    parameter int DATA_W = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              cmd_sel,
    input  logic              dack_n,
    input  logic [DATA_W-1:0] data,
    output logic              ev_valid,
    output logic              ev_cmd,
    output logic [DATA_W-1:0] ev_data
);
    localparam int W = DATA_W + 4;
    localparam logic [W-1:0] IDLE = {1'b1, 1'b1, 1'b0, 1'b1, {DATA_W{1'b0}}};

    logic [W-1:0] raw;
    logic [W-1:0] stg [STAGES+1];

    assign raw = {wr_n, cs_n, cmd_sel, dack_n, data};

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= IDLE;
                else        stg[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= IDLE;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    logic [W-1:0] cur;
    logic [W-1:0] prv;
    logic         rise;

    assign cur  = stg[STAGES-1];
    assign prv  = stg[STAGES];
    assign rise = cur[W-1] & ~prv[W-1];

    // fields are taken from the stage that still saw the strobe low
    assign ev_valid = rise & (~prv[W-2] | ~prv[W-4]);
    assign ev_cmd   = ~prv[W-2] & prv[W-3];
    assign ev_data  = prv[DATA_W-1:0];

endmodule

// File: rtl/linebuf_cmd_decode.sv
module linebuf_cmd_decode
    import linebuf_pkg::*;
(
    input  logic       ev_valid,
    input  logic       ev_cmd,
    input  logic [3:0] opcode,
    output cmd_e       cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (ev_valid && !ev_cmd) begin
            cmd = CMD_DATA;
        end else if (ev_valid) begin
            case (opcode)
                OPC_INIT:   cmd = CMD_INIT;
                OPC_REQCNT: cmd = CMD_REQCNT;
                OPC_LEAD:   cmd = CMD_LEAD;
                OPC_FMT:    cmd = CMD_FMT;
                OPC_MODE:   cmd = CMD_MODE;
                OPC_FILL:   cmd = CMD_FILL;
                OPC_REPEAT: cmd = CMD_REPEAT;
                OPC_STOP:   cmd = CMD_STOP;
                default:    cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/linebuf_ctrl.sv
module linebuf_ctrl
    import linebuf_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 320,
    parameter int SYNC_STAGES = 2,
    parameter int LEAD_W      = 12,
    parameter int COUNT_W     = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr_n,
    input  logic                       bus_cs_n,
    input  logic                       bus_cmd_sel,
    input  logic                       bus_dack_n,
    input  logic [DATA_W-1:0]          bus_data,
    input  logic                       send_done,
    output logic                       mem_we,
    output logic [$clog2(DEPTH)-1:0]   mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic                       send_start,
    output logic [$clog2(DEPTH+1)-1:0] line_words,
    output logic                       cfg_clk_sel,
    output logic [2:0]                 cfg_div,
    output logic                       cfg_fill_pol,
    output logic                       cfg_lead_en,
    output logic [LEAD_W-1:0]          cfg_lead_len,
    output logic                       cfg_lsb_first,
    output logic                       cfg_lifo,
    output logic                       dreq_n,
    output logic                       busy_n,
    output logic                       intr_n
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int FILL_W = COUNT_W + 1;
    localparam int CMP_W  = ((CNT_W > FILL_W) ? CNT_W : FILL_W) + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        mode_e               mode;
        init_cfg_t           init;
        logic [COUNT_W-1:0]  req_cnt;
        logic [LEAD_W-1:0]   lead_len;
        logic                lsb_first;
        logic                lifo;
        logic [CNT_W-1:0]    ptr;
        logic [FILL_W-1:0]   fill_rem;
        logic                req_act;
        logic                busy;
        logic                intr;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                start;
    } state_t;

    localparam state_t RESET_S = '{
        mode:      MODE_STATIC,
        init:      '0,
        req_cnt:   '0,
        lead_len:  '0,
        lsb_first: 1'b0,
        lifo:      1'b0,
        ptr:       '0,
        fill_rem:  '0,
        req_act:   1'b0,
        busy:      1'b0,
        intr:      1'b0,
        we:        1'b0,
        addr:      '0,
        wdata:     '0,
        start:     1'b0
    };

    logic              ev_valid;
    logic              ev_cmd;
    logic [DATA_W-1:0] ev_data;
    cmd_e              cmd;

    linebuf_bus_sync #(
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (bus_wr_n),
        .cs_n     (bus_cs_n),
        .cmd_sel  (bus_cmd_sel),
        .dack_n   (bus_dack_n),
        .data     (bus_data),
        .ev_valid (ev_valid),
        .ev_cmd   (ev_cmd),
        .ev_data  (ev_data)
    );

    linebuf_cmd_decode u_dec (
        .ev_valid (ev_valid),
        .ev_cmd   (ev_cmd),
        .opcode   (ev_data[DATA_W-1:DATA_W-4]),
        .cmd      (cmd)
    );

    state_t s_q, s_d;
    mode_e  mode_q;

    assign mode_q = s_q.mode;

    logic [CMP_W-1:0] req_limit;
    assign req_limit = CMP_W'(s_q.req_cnt) + CMP_W'(1);

    always_comb begin
        s_d       = s_q;
        s_d.we    = 1'b0;
        s_d.start = 1'b0;

        // any access drops the interrupt request
        if (ev_valid) s_d.intr = 1'b0;

        // completion from the serial engine
        if (s_q.mode == MODE_SEND && send_done) begin
            s_d.mode = MODE_SENT;
            s_d.busy = 1'b0;
            s_d.intr = 1'b1;
        end

        // fill sequencer: one word per cycle
        if (s_q.mode == MODE_WRITE && s_q.fill_rem != '0) begin
            s_d.fill_rem = s_q.fill_rem - FILL_W'(1);
            if (s_q.ptr < DEPTH_C) begin
                s_d.we    = 1'b1;
                s_d.addr  = ADDR_W'(s_q.ptr);
                s_d.wdata = {DATA_W{s_q.init.fill_pol}};
                s_d.ptr   = s_q.ptr + CNT_W'(1);
            end
        end

        case (cmd)
            CMD_DATA: begin
                if (s_q.mode == MODE_WRITE && s_q.fill_rem == '0 &&
                    s_q.ptr < DEPTH_C) begin
                    s_d.we    = 1'b1;
                    s_d.addr  = ADDR_W'(s_q.ptr);
                    s_d.wdata = ev_data;
                    s_d.ptr   = s_q.ptr + CNT_W'(1);
                end
            end
            CMD_INIT: begin
                if (s_q.mode == MODE_STATIC) begin
                    s_d.init.clk_sel  = ev_data[11];
                    s_d.init.div      = ev_data[10:8];
                    s_d.init.req_en   = ev_data[5];
                    s_d.init.lead_en  = ev_data[4];
                    s_d.init.fill_pol = ev_data[3];
                end
            end
            CMD_REQCNT: begin
                if (s_q.mode == MODE_STATIC) s_d.req_cnt = ev_data[COUNT_W-1:0];
            end
            CMD_LEAD: begin
                if (s_q.mode == MODE_STATIC) s_d.lead_len = ev_data[LEAD_W-1:0];
            end
            CMD_FMT: begin
                if (s_q.mode == MODE_STATIC) begin
                    s_d.lifo      = ev_data[1];
                    s_d.lsb_first = ev_data[0];
                end
            end
            CMD_MODE: begin
                if (ev_data[2:1] == 2'b00) begin
                    if (!ev_data[0] &&
                        (s_q.mode == MODE_STATIC || s_q.mode == MODE_SENT)) begin
                        s_d.mode     = MODE_WRITE;
                        s_d.ptr      = '0;
                        s_d.fill_rem = '0;
                        s_d.req_act  = s_q.init.req_en & ~ev_data[3];
                    end else if (ev_data[0] && s_q.mode == MODE_WRITE &&
                                 s_q.fill_rem == '0) begin
                        s_d.mode    = MODE_SEND;
                        s_d.busy    = 1'b1;
                        s_d.start   = 1'b1;
                        s_d.req_act = 1'b0;
                    end
                end
            end
            CMD_FILL: begin
                if (s_q.mode == MODE_WRITE) begin
                    s_d.fill_rem = FILL_W'(ev_data[COUNT_W-1:0]) + FILL_W'(1);
                end
            end
            CMD_REPEAT: begin
                if (s_q.mode == MODE_SENT) begin
                    s_d.mode  = MODE_SEND;
                    s_d.busy  = 1'b1;
                    s_d.start = 1'b1;
                end
            end
            CMD_STOP: begin
                s_d.mode     = MODE_STATIC;
                s_d.ptr      = '0;
                s_d.fill_rem = '0;
                s_d.req_act  = 1'b0;
                s_d.busy     = 1'b0;
                s_d.intr     = 1'b0;
                s_d.start    = 1'b0;
            end
            default: ;
        endcase

        // request is withdrawn once N+1 words are stored
        if (s_d.req_act && CMP_W'(s_d.ptr) >= req_limit) s_d.req_act = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_S;
        else        s_q <= s_d;
    end

    assign mem_we        = s_q.we;
    assign mem_addr      = s_q.addr;
    assign mem_wdata     = s_q.wdata;
    assign send_start    = s_q.start;
    assign line_words    = s_q.ptr;
    assign cfg_clk_sel   = s_q.init.clk_sel;
    assign cfg_div       = s_q.init.div;
    assign cfg_fill_pol  = s_q.init.fill_pol;
    assign cfg_lead_en   = s_q.init.lead_en;
    assign cfg_lead_len  = s_q.lead_len;
    assign cfg_lsb_first = s_q.lsb_first;
    assign cfg_lifo      = s_q.lifo;
    assign dreq_n        = ~s_q.req_act;
    assign busy_n        = ~s_q.busy;
    assign intr_n        = ~s_q.intr;

endmodule

// File: rtl/linebuf_ctrl_chk.sv
module linebuf_ctrl_chk
    import linebuf_pkg::*;
#(
    parameter int DEPTH  = 320,
    parameter int ADDR_W = 9,
    parameter int LEAD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input mode_e             mode_q,
    input logic              ev_valid,
    input logic              ev_cmd,
    input logic              send_done,
    input logic              send_start,
    input logic              busy_n,
    input logic              intr_n,
    input logic              dreq_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cfg_clk_sel,
    input logic [2:0]        cfg_div,
    input logic              cfg_fill_pol,
    input logic [LEAD_W-1:0] cfg_lead_len,
    input logic              cfg_lsb_first,
    input logic              cfg_lifo
);
    // R2: memory writes only follow a cycle spent in write mode
    a_r2_we_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mode_q) == MODE_WRITE);

    // R4: address never leaves the line
    a_r4_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> int'(mem_addr) < DEPTH);

    // R6: request only while filling
    a_r6_req_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !dreq_n |-> mode_q == MODE_WRITE);

    // R3: configuration frozen outside static mode
    a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_STATIC |=> $stable({cfg_clk_sel, cfg_div, cfg_fill_pol,
                                           cfg_lead_len, cfg_lsb_first, cfg_lifo}));

    // R7: start is a single-cycle pulse that coincides with busy
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        send_start |-> !busy_n ##1 !send_start);

    // R8: completion raises ready and requests an interrupt together
    a_r8_done_intr: assert property (@(posedge clk) disable iff (!rst_n)
        (send_done && !busy_n && !(ev_valid && ev_cmd)) |=> (busy_n && !intr_n));

endmodule

bind linebuf_ctrl linebuf_ctrl_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W ($clog2(DEPTH)),
    .LEAD_W (LEAD_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_q        (mode_q),
    .ev_valid      (ev_valid),
    .ev_cmd        (ev_cmd),
    .send_done     (send_done),
    .send_start    (send_start),
    .busy_n        (busy_n),
    .intr_n        (intr_n),
    .dreq_n        (dreq_n),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .cfg_clk_sel   (cfg_clk_sel),
    .cfg_div       (cfg_div),
    .cfg_fill_pol  (cfg_fill_pol),
    .cfg_lead_len  (cfg_lead_len),
    .cfg_lsb_first (cfg_lsb_first),
    .cfg_lifo      (cfg_lifo)
);

// File: tb/tb_linebuf_ctrl.sv
module tb_linebuf_ctrl;
    localparam int DEPTH = 320;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1, cs_n = 1'b1, cmd_sel = 1'b0, dack_n = 1'b1;
    logic [15:0] din = '0;
    logic        send_done = 1'b0;
    logic        mem_we, send_start;
    logic [8:0]  mem_addr, line_words;
    logic [15:0] mem_wdata;
    logic        cfg_clk_sel, cfg_fill_pol, cfg_lead_en, cfg_lsb_first, cfg_lifo;
    logic [2:0]  cfg_div;
    logic [11:0] cfg_lead_len;
    logic        dreq_n, busy_n, intr_n;

    always #5 clk = ~clk;

    linebuf_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_n(wr_n), .bus_cs_n(cs_n),
        .bus_cmd_sel(cmd_sel), .bus_dack_n(dack_n), .bus_data(din),
        .send_done(send_done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .send_start(send_start), .line_words(line_words),
        .cfg_clk_sel(cfg_clk_sel), .cfg_div(cfg_div), .cfg_fill_pol(cfg_fill_pol),
        .cfg_lead_en(cfg_lead_en), .cfg_lead_len(cfg_lead_len),
        .cfg_lsb_first(cfg_lsb_first), .cfg_lifo(cfg_lifo),
        .dreq_n(dreq_n), .busy_n(busy_n), .intr_n(intr_n)
    );

    // port-side capture of the memory write port
    logic [15:0] mem_m [DEPTH];
    int we_cnt = 0;
    int start_cnt = 0;
    always @(posedge clk) begin
        if (mem_we) begin
            mem_m[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (send_start) start_cnt <= start_cnt + 1;
    end

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic bus(input logic c, input logic sel, input logic d, input logic [15:0] v);
        @(negedge clk);
        cs_n = c; cmd_sel = sel; dack_n = d; din = v;
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b1; dack_n = 1'b1;
    endtask

    task automatic cmd(input logic [15:0] v);
        bus(1'b0, 1'b1, 1'b1, v);
    endtask

    task automatic pulse_done();
        @(negedge clk); send_done = 1'b1;
        @(negedge clk); send_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            report();
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 dreq_n", dreq_n, 1);
        check("R13 busy_n", busy_n, 1);
        check("R13 intr_n", intr_n, 1);
        check("R13 cfg", {cfg_clk_sel, cfg_div, cfg_fill_pol, cfg_lead_en,
                          cfg_lsb_first, cfg_lifo}, 0);
        check("R13 we", we_cnt, 0);

        // R3 static configuration
        cmd(16'h8B38);
        check("R3 clk_sel", cfg_clk_sel, 1);
        check("R3 div", cfg_div, 3);
        check("R3 lead_en", cfg_lead_en, 1);
        check("R3 fill_pol", cfg_fill_pol, 1);
        cmd(16'h7004);
        cmd(16'h6064);
        check("R3 lead_len", cfg_lead_len, 100);
        cmd(16'h4003);
        check("R3 lsb", cfg_lsb_first, 1);
        check("R3 lifo", cfg_lifo, 1);

        // R6 enter write with request enabled
        cmd(16'h0000);
        check("R6 dreq low on write", dreq_n, 0);
        check("R2 line_words reset", line_words, 0);
        cmd(16'h8000);
        check("R3 init ignored in write", cfg_clk_sel, 1);

        // R6 / R1 / R2 DMA words
        for (int i = 0; i < 5; i++) begin
            bus(1'b1, 1'b0, 1'b0, 16'hA500 + 16'(i));
            if (i == 3) check("R6 dreq held before N+1", dreq_n, 0);
        end
        check("R6 dreq released at N+1", dreq_n, 1);
        bus(1'b1, 1'b0, 1'b1, 16'hDEAD);
        check("R1 no select no write", we_cnt, 5);
        bus(1'b0, 1'b0, 1'b1, 16'h1234);
        check("R1 cpu data write", we_cnt, 6);
        check("R1 cpu data value", mem_m[5], 16'h1234);
        for (int i = 0; i < 5; i++) check("R2 stored word", mem_m[i], 16'hA500 + i);
        check("R2 line_words", line_words, 6);

        // R7 send
        cmd(16'h0001);
        check("R7 start pulse", start_cnt, 1);
        check("R7 busy low", busy_n, 0);
        check("R7 line_words", line_words, 6);
        bus(1'b0, 1'b0, 1'b1, 16'h5555);
        check("R7 data ignored while busy", we_cnt, 6);
        cmd(16'h4000);
        check("R7 fmt ignored while busy", cfg_lsb_first, 1);
        cmd(16'h2000);
        check("R11 repeat ignored while busy", start_cnt, 1);

        // R8 completion
        pulse_done();
        check("R8 busy high", busy_n, 1);
        check("R8 intr low", intr_n, 0);
        bus(1'b0, 1'b0, 1'b1, 16'h7777);
        check("R9 access clears intr", intr_n, 1);
        check("R2 data ignored after send", we_cnt, 6);

        // R11 repeat
        cmd(16'h2000);
        check("R11 repeat start", start_cnt, 2);
        check("R11 busy", busy_n, 0);
        check("R11 same length", line_words, 6);
        pulse_done();
        cmd(16'h0001);
        check("R5 send from sent ignored", start_cnt, 2);

        // R12 stop keeps configuration
        cmd(16'hF000);
        check("R12 busy", busy_n, 1);
        check("R12 intr", intr_n, 1);
        check("R12 clk_sel kept", cfg_clk_sel, 1);
        check("R12 div kept", cfg_div, 3);
        check("R12 lead kept", cfg_lead_len, 100);
        check("R12 lsb kept", cfg_lsb_first, 1);
        check("R12 words cleared", line_words, 0);

        // R5 malformed mode word ignored
        cmd(16'h0002);
        bus(1'b0, 1'b0, 1'b1, 16'h0BAD);
        check("R5 bad mode ignored", we_cnt, 6);
        cmd(16'h0001);
        check("R5 send from static ignored", start_cnt, 2);

        // R10 fill ignored in static
        cmd(16'h3005);
        repeat (20) @(negedge clk);
        check("R10 fill ignored in static", we_cnt, 6);

        // R10 fill sweep with mask set
        for (int k = 0; k < 4; k++) begin
            int w;
            w = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 7 : 20;
            cmd(16'hF000);
            cmd(16'h0008);
            check("R6 masked", dreq_n, 1);
            base = we_cnt;
            cmd(16'h3000 | 16'(w));
            repeat (w + 10) @(negedge clk);
            check("R10 fill count", we_cnt - base, w + 1);
            check("R10 line_words", line_words, w + 1);
            for (int j = 0; j <= w; j++) check("R10 fill value", mem_m[j], 16'hFFFF);
        end

        // R4 overflow
        cmd(16'hF000);
        cmd(16'h0008);
        base = we_cnt;
        cmd(16'h3190);
        repeat (420) @(negedge clk);
        check("R4 capped writes", we_cnt - base, DEPTH);
        check("R4 capped count", line_words, DEPTH);
        bus(1'b0, 1'b0, 1'b1, 16'h4444);
        check("R4 extra data dropped", we_cnt - base, DEPTH);

        // R3 reconfigure in static, R10 low polarity
        cmd(16'hF000);
        cmd(16'h8000);
        check("R3 pol cleared", cfg_fill_pol, 0);
        check("R3 clk cleared", cfg_clk_sel, 0);
        cmd(16'h0000);
        check("R6 disabled request", dreq_n, 1);
        cmd(16'h3002);
        repeat (12) @(negedge clk);
        for (int j = 0; j < 3; j++) check("R10 low fill", mem_m[j], 0);

        // R12 stop during send
        cmd(16'h0001);
        check("R7 busy again", busy_n, 0);
        cmd(16'hF000);
        check("R12 stop in send", busy_n, 1);
        check("R12 no intr", intr_n, 1);

        done_flag = 1;
        report();
    end
endmodule